// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is the host side of a simple parallel printer port. It sits on a small I/O bus that is separate from memory. The bus has a 10-bit address, an I/O select, read and write strobes, and 8-bit data. The block decodes three byte-wide registers at fixed I/O addresses:

- a data register, whose contents drive the printer data lines;
- a status register, which reports whether the printer can take another byte;
- a control register, whose lowest bit drives the printer strobe line.

Software sends a byte in four steps. It polls the status register until the ready bit is 1. It writes the byte to the data register. It writes the control register with bit 0 set, then writes it again with bit 0 clear. The strobe line follows that register bit directly, so software sets the pulse width.

The printer's busy input is asynchronous, so it passes through a two-flop synchronizer before it reaches the status bit. Read data is registered. It appears one clock after the clock edge on which the read is sampled, and it is zero in every cycle that has no decoded read.

Top module: `lpt_port`

## Requirements
- R1: A write (io_sel=1, io_wr=1) to address 0x378 stores io_wdata in the data register. prn_data shows that byte from the clock edge on which the write is sampled.
- R2: A read (io_sel=1, io_rd=1) of 0x378 returns the last byte written to the data register. io_rdata carries the value from the edge on which the read is sampled until the next edge.
- R3: A write to 0x37A stores all 8 bits of the control register, and a read of 0x37A returns them. prn_strobe equals control bit 0 and updates on the same edge as the write.
- R4: A read of 0x379 returns bit 7 = 1 when the synchronized busy input is low (printer ready) and bit 7 = 0 when it is high. Bits 6..0 always read 0.
- R5: prn_busy passes through two synchronizer flops, and both flops reset to the busy state. After prn_busy changes, status reads sampled on the first two following edges still show the old state. A read on the third edge shows the new state.
- R6: While io_sel=0, no register changes, whatever the address or strobes, and io_rdata reads 0.
- R7: An access with io_sel=1 to any address other than 0x378..0x37A changes no register, and a read there returns 0.
- R8: After reset, prn_data=0x00, prn_strobe=0, io_rdata=0x00, and the data and control registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | I/O address |
| io_sel | input | 1 | I/O cycle select (high for I/O space, low for memory) |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, zero when there is no decoded read |
| prn_data | output | 8 | Printer data lines |
| prn_strobe | output | 1 | Printer strobe line |
| prn_busy | input | 1 | Asynchronous busy signal from the printer, high while busy |

## Verification
The bench targets four kinds of error:

- **Decode.** It sweeps all 1024 I/O addresses with the select high and then low, and checks that nothing outside the three decoded locations changes any state or returns data. A decoder that ignored the upper address bits, or that responded to memory cycles, would corrupt the data lines or the strobe.
- **Register contents.** It writes and reads back every byte value in the data and control registers. This catches a strobe tied to the wrong bit, or a register that drops bits.
- **Synchronizer latency.** After each change of the busy input, it reads status on back-to-back edges. A missing or extra flop moves the edge at which the ready bit changes.
- **End-to-end transfer.** A handshaking printer model receives several bytes, and the bench compares what the model captured with what was sent.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  // One select line per decoded register; at most one is high at a time.
  typedef struct packed {
    logic data;
    logic stat;
    logic ctrl;
  } lpt_sel_t;

endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h378
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_sel,
  output lpt_sel_t          sel_o
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + ADDR_W'(2);

  // Full address compare: every address bit takes part, and only I/O cycles respond.
  always_comb begin
    sel_o.data = io_sel && (io_addr == DATA_ADDR);
    sel_o.stat = io_sel && (io_addr == STAT_ADDR);
    sel_o.ctrl = io_sel && (io_addr == CTRL_ADDR);
  end

endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STROBE_BIT = 0,
  parameter int READY_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  lpt_sel_t          sel,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              busy_sync,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe
);

  localparam logic [DATA_W-1:0] READY_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << READY_BIT;

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;

  // Status: only the ready bit is live; ready is the inverse of the synchronized busy.
  always_comb begin
    status_w            = '0;
    status_w[READY_BIT] = ~busy_sync;
  end

  always_comb begin
    rd_mux = '0;
    if (io_rd) begin
      if (sel.data) rd_mux = data_q;
      if (sel.stat) rd_mux = status_w;
      if (sel.ctrl) rd_mux = ctrl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (io_wr && sel.data) data_q <= io_wdata;
      if (io_wr && sel.ctrl) ctrl_q <= io_wdata;
      rdata_q <= rd_mux;
    end
  end

  assign io_rdata   = rdata_q;
  assign prn_data   = data_q;
  assign prn_strobe = ctrl_q[STROBE_BIT];

  assert_data_latch_R1: assert property (@(posedge clk) disable iff (rst)
    (sel.data && io_wr) |=> (prn_data == $past(io_wdata)));

  assert_strobe_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (sel.ctrl && io_wr) |=> (prn_strobe == $past(io_wdata[STROBE_BIT])));

  assert_status_pad_R4: assert property (@(posedge clk) disable iff (rst)
    (sel.stat && io_rd) |=> ((io_rdata & ~READY_MASK) == '0));

  assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (rst)
    !((sel.data || sel.stat || sel.ctrl) && io_rd) |=> (io_rdata == '0));

endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
#(
  parameter int                ADDR_W      = 10,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h378,
  parameter int                SYNC_STAGES = 2,
  parameter int                STROBE_BIT  = 0,
  parameter int                READY_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_sel,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe,
  input  logic              prn_busy
);

  lpt_sel_t sel;
  logic     busy_sync;

  lpt_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .io_addr(io_addr),
    .io_sel (io_sel),
    .sel_o  (sel)
  );

  lpt_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (prn_busy),
    .q  (busy_sync)
  );

  lpt_regs #(
    .DATA_W    (DATA_W),
    .STROBE_BIT(STROBE_BIT),
    .READY_BIT (READY_BIT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .busy_sync (busy_sync),
    .io_rdata  (io_rdata),
    .prn_data  (prn_data),
    .prn_strobe(prn_strobe)
  );

  assert_one_reg_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.data, sel.stat, sel.ctrl}));

  assert_no_select_R6: assert property (@(posedge clk) disable iff (rst)
    !io_sel |=> ($stable(prn_data) && $stable(prn_strobe)));

endmodule

// File: tb/tb_lpt_port.sv
`timescale 1ns/1ps
module tb_lpt_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] io_addr = '0;
  logic       io_sel = 1'b0;
  logic       io_rd = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [7:0] prn_data;
  logic       prn_strobe;
  logic       prn_busy;

  logic       manual_busy = 1'b0;
  logic       model_on = 1'b0;
  logic       model_busy = 1'b0;
  logic       strobe_d = 1'b0;
  int         bcnt = 0;
  int         cap_n = 0;
  logic [7:0] captured [0:15];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  assign prn_busy = model_on ? model_busy : manual_busy;

  always #2 clk = ~clk;

  lpt_port dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_sel(io_sel), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .prn_data(prn_data),
    .prn_strobe(prn_strobe), .prn_busy(prn_busy)
  );

  // Printer model: takes the byte on a rising strobe, then stays busy for a few cycles.
  always @(negedge clk) begin
    strobe_d <= prn_strobe;
    if (model_on && prn_strobe && !strobe_d) begin
      captured[cap_n[3:0]] <= prn_data;
      cap_n      <= cap_n + 1;
      model_busy <= 1'b1;
      bcnt       <= 5;
    end else if (bcnt != 0) begin
      bcnt <= bcnt - 1;
      if (bcnt == 1) model_busy <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Each access takes one clock: drive at a falling edge, sample at the next falling edge.
  task automatic io_write(input logic [9:0] a, input logic [7:0] d, input logic s);
    io_addr = a; io_wdata = d; io_sel = s; io_wr = 1'b1; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0; io_sel = 1'b0;
  endtask

  task automatic io_read(input logic [9:0] a, input logic s, output logic [7:0] d);
    io_addr = a; io_sel = s; io_rd = 1'b1; io_wr = 1'b0;
    @(negedge clk);
    d = io_rdata;
    io_rd = 1'b0; io_sel = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    check("R8 prn_data", prn_data, 8'h00);
    check("R8 strobe", {7'b0, prn_strobe}, 8'h00);
    check("R8 rdata", io_rdata, 8'h00);
    io_read(10'h378, 1'b1, r); check("R8 data reg", r, 8'h00);
    io_read(10'h37A, 1'b1, r); check("R8 ctrl reg", r, 8'h00);

    // R4: status reads ready once the synchronizer has settled with busy low
    repeat (3) @(negedge clk);
    io_read(10'h379, 1'b1, r); check("R4 ready", r, 8'h80);

    // R5: busy rises; two reads still see ready, the third sees busy
    manual_busy = 1'b1;
    io_read(10'h379, 1'b1, r); check("R5 lag1 rise", r, 8'h80);
    io_read(10'h379, 1'b1, r); check("R5 lag2 rise", r, 8'h80);
    io_read(10'h379, 1'b1, r); check("R5 R4 busy", r, 8'h00);
    manual_busy = 1'b0;
    io_read(10'h379, 1'b1, r); check("R5 lag1 fall", r, 8'h00);
    io_read(10'h379, 1'b1, r); check("R5 lag2 fall", r, 8'h00);
    io_read(10'h379, 1'b1, r); check("R5 R4 ready", r, 8'h80);

    // R1 R2: every data value
    for (int v = 0; v < 256; v++) begin
      io_write(10'h378, 8'(v), 1'b1);
      check("R1 prn_data", prn_data, 8'(v));
      io_read(10'h378, 1'b1, r); check("R2 readback", r, 8'(v));
    end

    // R3: every control value, strobe tracks bit 0
    for (int v = 0; v < 256; v++) begin
      io_write(10'h37A, 8'(v), 1'b1);
      check("R3 strobe", {7'b0, prn_strobe}, {7'b0, v[0]});
      io_read(10'h37A, 1'b1, r); check("R3 readback", r, 8'(v));
    end

    // R7: all other addresses with select high
    io_write(10'h378, 8'hA5, 1'b1);
    io_write(10'h37A, 8'h5A, 1'b1);
    for (int a = 0; a < 1024; a++) begin
      if (a >= 10'h378 && a <= 10'h37A) continue;
      io_write(10'(a), 8'hFF, 1'b1);
      check("R7 prn_data", prn_data, 8'hA5);
      check("R7 strobe", {7'b0, prn_strobe}, 8'h00);
      io_read(10'(a), 1'b1, r); check("R7 rdata", r, 8'h00);
    end
    io_read(10'h378, 1'b1, r); check("R7 data kept", r, 8'hA5);
    io_read(10'h37A, 1'b1, r); check("R7 ctrl kept", r, 8'h5A);

    // R6: select low, every address
    for (int a = 0; a < 1024; a++) begin
      io_write(10'(a), 8'hFF, 1'b0);
      check("R6 prn_data", prn_data, 8'hA5);
      check("R6 strobe", {7'b0, prn_strobe}, 8'h00);
      io_read(10'(a), 1'b0, r); check("R6 rdata", r, 8'h00);
    end
    io_read(10'h37A, 1'b1, r); check("R6 ctrl kept", r, 8'h5A);

    // R1 R3 R4: full handshake against the printer model
    io_write(10'h37A, 8'h00, 1'b1);
    model_on = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      int polls = 0;
      r = 8'h00;
      while (((r & 8'h80) == 0) && polls < 100) begin
        io_read(10'h379, 1'b1, r);
        polls++;
      end
      check("R4 ready poll", r & 8'h80, 8'h80);
      io_write(10'h378, 8'(i * 37 + 11), 1'b1);
      io_write(10'h37A, 8'h01, 1'b1);
      io_write(10'h37A, 8'h00, 1'b1);
    end
    repeat (10) @(negedge clk);
    check("R1 R3 byte count", 8'(cap_n), 8'd6);
    for (int i = 0; i < 6; i++)
      check("R1 R3 captured", captured[i], 8'(i * 37 + 11));

    done = 1;
    finish_up();
  end

endmodule